// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block decides, every cycle, whether a hart should leave its current code to service an interrupt, and if so which one. It sees the pending interrupt bits and the delegation mask. It also sees the current privilege level, the machine and supervisor global enables, and a flag that says the hart is halted in debug mode. It first qualifies the pending bits by privilege. It then splits them into a machine-level group and a delegated group, and picks one interrupt by a fixed class order. Within the winning class, the lowest-numbered bit wins.

The decision is registered. A one-cycle `take_o` strobe is raised together with the interrupt cause word. The cause word stays on `cause_o` until the trap logic raises `accept_i`. After that, `cause_o` returns to zero and the arbiter may fire again.

Top module: `irq_priority_arbiter`

## Requirements
- R1: When `rst_n` is low at a clock edge, `take_o` is 0 and `cause_o` is 0 after that edge.
- R2: A pending bit that is not delegated (its `deleg_i` bit is 0) is eligible when the privilege is below machine (`priv_i` is 0 for user or 1 for supervisor), or when `priv_i` is 3 (machine) and `m_ie_i` is 1.
- R3: A pending bit that is delegated is eligible when `priv_i` is 0, or when `priv_i` is 1 and `s_ie_i` is 1. It is never eligible at `priv_i` 3.
- R4: While any eligible non-delegated bit exists, delegated bits are not considered, even if one of them is in a higher class.
- R5: While `dbg_mode_i` is 1, no interrupt is taken.
- R6: Classes in falling priority: any bit at position 12 or above; external (bits 9 and 11); software (bits 1 and 3); timer (bits 5 and 7).
- R7: Within the winning class, the lowest-numbered set bit gives the cause index.
- R8: On a take, `cause_o` has bit XLEN-1 set, the index in its low $clog2(XLEN) bits, and all other bits zero.
- R9: `take_o` is high for exactly one cycle per taken interrupt, one clock edge after the inputs that cause it.
- R10: After a take, `cause_o` holds its value and no further take occurs until `accept_i` is sampled high. At that edge `cause_o` returns to 0, and a take is possible again at the following edge.
- R11: If the selected group holds only bits 0, 2, 4, 6, 8 or 10, no interrupt is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | XLEN | Pending interrupt bits |
| deleg_i | input | XLEN | Delegation mask, 1 means supervisor handles it |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_ie_i | input | 1 | Machine global interrupt enable |
| s_ie_i | input | 1 | Supervisor global interrupt enable |
| dbg_mode_i | input | 1 | Hart is in debug mode |
| accept_i | input | 1 | Trap logic has consumed the cause |
| take_o | output | 1 | One-cycle strobe: interrupt taken |
| cause_o | output | XLEN | Interrupt cause word |

## Verification
The bench aims at the group split. A delegated external interrupt is pending alongside a non-delegated timer interrupt. A design that merged the groups before the class sort would report the external cause instead of the timer cause. A second target is the class ladder, where a pure lowest-bit pick would choose software over a bit above 11. Within a class, a highest-bit pick would report 11 instead of 9.

Three further cases are covered. Bits that belong to no class must not trigger a take, so a design that fell through to a trailing-zero count would wrongly fire on them. Machine privilege with the machine enable low must block everything, including delegated bits. The hold window is driven with a new, higher interrupt pending. A design that did not latch the cause until accept would show a second strobe or a changing cause.

// File: rtl/irq_arb_pkg.sv
// Shared definitions for the interrupt priority arbiter.
// Assumes the standard bit layout of the pending vector: software at
// 1/3, timer at 5/7, external at 9/11, custom sources at 12 and above.
package irq_arb_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    localparam int unsigned TOP_STD_BIT = 11;
    localparam int unsigned SW_S_BIT    = 1;
    localparam int unsigned SW_M_BIT    = 3;
    localparam int unsigned TMR_S_BIT   = 5;
    localparam int unsigned TMR_M_BIT   = 7;
    localparam int unsigned EXT_S_BIT   = 9;
    localparam int unsigned EXT_M_BIT   = 11;

endpackage

// File: rtl/irq_enable_split.sv
// Qualifies pending interrupts by privilege and global enables and picks
// the group to arbitrate: the machine-level group when it holds any
// eligible bit, otherwise the delegated group.
// Assumes priv_i is already legal; reserved level 2 counts as above S.
module irq_enable_split
    import irq_arb_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            m_ie_i,
    input  logic            s_ie_i,
    output logic [XLEN-1:0] group_o
);

    logic            m_on;
    logic            s_on;
    logic [XLEN-1:0] m_grp;
    logic [XLEN-1:0] s_grp;

    // Per-level enable from privilege and global enable bits
    always_comb begin
        m_on = (priv_i != PRIV_MACH) || m_ie_i;
        s_on = (priv_i == PRIV_USER) || ((priv_i == PRIV_SUPER) && s_ie_i);
    end

    // Group masking, machine group wins whenever non-empty
    always_comb begin
        m_grp   = pend_i & ~deleg_i & {XLEN{m_on}};
        s_grp   = pend_i &  deleg_i & {XLEN{s_on}};
        group_o = (m_grp != '0) ? m_grp : s_grp;
    end

endmodule

// File: rtl/irq_class_pick.sv
// Applies fixed class priority to a group of eligible interrupt bits and
// keeps only the bits of the highest non-empty class.
// Assumes XLEN is larger than 12 so the custom class exists.
module irq_class_pick
    import irq_arb_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] group_i,
    output logic [XLEN-1:0] class_o,
    output logic            valid_o
);

    localparam logic [XLEN-1:0] ONE      = XLEN'(1);
    localparam logic [XLEN-1:0] HI_MASK  = ~((ONE << (TOP_STD_BIT + 1)) - ONE);
    localparam logic [XLEN-1:0] EXT_MASK = (ONE << EXT_S_BIT) | (ONE << EXT_M_BIT);
    localparam logic [XLEN-1:0] SW_MASK  = (ONE << SW_S_BIT)  | (ONE << SW_M_BIT);
    localparam logic [XLEN-1:0] TMR_MASK = (ONE << TMR_S_BIT) | (ONE << TMR_M_BIT);

    // Walk the class ladder from highest to lowest
    always_comb begin
        if ((group_i & HI_MASK) != '0)
            class_o = group_i & HI_MASK;
        else if ((group_i & EXT_MASK) != '0)
            class_o = group_i & EXT_MASK;
        else if ((group_i & SW_MASK) != '0)
            class_o = group_i & SW_MASK;
        else
            class_o = group_i & TMR_MASK;
        valid_o = (class_o != '0);
    end

endmodule

// File: rtl/irq_lsb_index.sv
// Returns the index of the lowest set bit of a vector (trailing zero
// count). Output is 0 for an all-zero vector; callers gate with valid.
module irq_lsb_index #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned IW   = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] vec_i,
    output logic [IW-1:0]   idx_o
);

    // Scan downward so the lowest set bit is written last
    always_comb begin
        idx_o = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/irq_priority_arbiter.sv
// Interrupt priority arbiter top. Combines group selection, class
// priority and lowest-bit index, then registers a one-cycle take strobe
// and a cause word that is held until the trap logic accepts it.
// Assumes XLEN is 32 or 64 and inputs are synchronous to clk.
module irq_priority_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            m_ie_i,
    input  logic            s_ie_i,
    input  logic            dbg_mode_i,
    input  logic            accept_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);

    localparam int unsigned IW = $clog2(XLEN);

    logic [XLEN-1:0] group_v;
    logic [XLEN-1:0] class_v;
    logic            class_ok;
    logic [IW-1:0]   bit_idx;
    logic [XLEN-1:0] cause_n;
    logic            held_q;

    irq_enable_split #(.XLEN(XLEN)) i_split (
        .pend_i  (pend_i),
        .deleg_i (deleg_i),
        .priv_i  (priv_i),
        .m_ie_i  (m_ie_i),
        .s_ie_i  (s_ie_i),
        .group_o (group_v)
    );

    irq_class_pick #(.XLEN(XLEN)) i_class (
        .group_i (group_v),
        .class_o (class_v),
        .valid_o (class_ok)
    );

    irq_lsb_index #(.XLEN(XLEN), .IW(IW)) i_index (
        .vec_i (class_v),
        .idx_o (bit_idx)
    );

    // Assemble the cause word: interrupt flag on top, index at the bottom
    always_comb begin
        cause_n                  = '0;
        cause_n[XLEN-1]          = 1'b1;
        cause_n[IW-1:0]          = bit_idx;
    end

    // Strobe, cause hold and accept handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o  <= 1'b0;
            held_q  <= 1'b0;
            cause_o <= '0;
        end else if (held_q) begin
            take_o <= 1'b0;
            if (accept_i) begin
                held_q  <= 1'b0;
                cause_o <= '0;
            end
        end else if (class_ok && !dbg_mode_i) begin
            take_o  <= 1'b1;
            held_q  <= 1'b1;
            cause_o <= cause_n;
        end else begin
            take_o <= 1'b0;
        end
    end

    // Strobe never lasts two cycles
    p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // Cause is frozen until accepted
    p_cause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o != '0 && !accept_i) |=> $stable(cause_o));

    // Cause word format on every take
    p_cause_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:IW] == '0)));

    // Debug mode blocks the decision that produced a take
    p_no_dbg_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !$past(dbg_mode_i));

    // Index points at a set bit with nothing set below it
    p_lowest_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        class_ok |-> (class_v[bit_idx] &&
                      ((class_v & ((XLEN'(1) << bit_idx) - XLEN'(1))) == '0)));

    // Winning class is a subset of the selected group
    p_class_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (class_v & ~group_v) == '0);

endmodule

// File: tb/test_irq_priority_arbiter.sv
`timescale 1ns/1ps
module test_irq_priority_arbiter;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] pend_i = '0;
    logic [XLEN-1:0] deleg_i = '0;
    logic [1:0]      priv_i = 2'd3;
    logic            m_ie_i = 1'b0;
    logic            s_ie_i = 1'b0;
    logic            dbg_mode_i = 1'b0;
    logic            accept_i = 1'b0;
    logic            take_o;
    logic [XLEN-1:0] cause_o;

    int checks = 0;
    int errors = 0;
    logic [XLEN-1:0] exp_q[$];
    string           tag_q[$];

    always #10 clk = ~clk;

    irq_priority_arbiter #(.XLEN(XLEN)) i_irq_priority_arbiter (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .deleg_i(deleg_i),
        .priv_i(priv_i), .m_ie_i(m_ie_i), .s_ie_i(s_ie_i),
        .dbg_mode_i(dbg_mode_i), .accept_i(accept_i),
        .take_o(take_o), .cause_o(cause_o)
    );

    // Reference model written from the requirements; bit 32 = valid
    function automatic logic [XLEN:0] model(input logic [XLEN-1:0] p,
        input logic [XLEN-1:0] d, input logic [1:0] pv, input logic mie,
        input logic sie, input logic dbg);
        logic [XLEN-1:0] grp, cls, nd, dl;
        logic men, sen;
        men = (pv == 2'd0) || (pv == 2'd1) || (pv == 2'd3 && mie);
        sen = (pv == 2'd0) || (pv == 2'd1 && sie);
        nd  = men ? (p & ~d) : '0;
        dl  = sen ? (p & d) : '0;
        grp = (nd != 0) ? nd : dl;
        if ((grp & 32'hFFFF_F000) != 0)       cls = grp & 32'hFFFF_F000;
        else if ((grp & 32'h0000_0A00) != 0)  cls = grp & 32'h0000_0A00;
        else if ((grp & 32'h0000_000A) != 0)  cls = grp & 32'h0000_000A;
        else                                  cls = grp & 32'h0000_00A0;
        if (dbg || cls == 0) return '0;
        for (int i = 0; i < XLEN; i++)
            if (cls[i]) return {1'b1, 1'b1, 26'd0, 5'(i)};
        return '0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n && take_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected take", cause_o, '0);
            end else begin
                logic [XLEN-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(cause_o == e, t, cause_o, e);
            end
        end
    end

    // Driver: apply inputs, push expectation, confirm consumption
    task automatic drive(input logic [XLEN-1:0] p, input logic [XLEN-1:0] d,
        input logic [1:0] pv, input logic mie, input logic sie, input logic dbg,
        input string req, output bit fired);
        logic [XLEN:0] m;
        @(negedge clk);
        pend_i = p; deleg_i = d; priv_i = pv; m_ie_i = mie; s_ie_i = sie;
        dbg_mode_i = dbg;
        m = model(p, d, pv, mie, sie, dbg);
        fired = m[XLEN];
        if (fired) begin
            exp_q.push_back(m[XLEN-1:0]);
            tag_q.push_back(req);
        end
        @(posedge clk);
        @(negedge clk);
        #2;
        if (fired) check(exp_q.size() == 0, {req, " missing take"}, {31'd0, take_o}, 1);
        else       check(take_o == 1'b0, {req, " no take"}, {31'd0, take_o}, 0);
    endtask

    // Accept the held cause and clear inputs
    task automatic release_cause(input bit fired);
        @(negedge clk);
        pend_i = '0; deleg_i = '0; dbg_mode_i = 1'b0;
        accept_i = fired;
        @(negedge clk);
        accept_i = 1'b0;
        if (fired) check(cause_o == '0, "R10 cleared after accept", cause_o, '0);
    endtask

    task automatic scenario(input logic [XLEN-1:0] p, input logic [XLEN-1:0] d,
        input logic [1:0] pv, input logic mie, input logic sie, input logic dbg,
        input string req);
        bit f;
        drive(p, d, pv, mie, sie, dbg, req, f);
        release_cause(f);
    endtask

    initial begin
        bit f;
        repeat (3) @(negedge clk);
        check(take_o == 1'b0 && cause_o == '0, "R1 reset state", cause_o, '0);
        rst_n = 1'b1;

        scenario(32'h80, 0, 2'd3, 1, 0, 0, "R2 M mode enabled");
        scenario(32'h80, 0, 2'd3, 0, 0, 0, "R2 M mode disabled");
        scenario(32'h08, 0, 2'd0, 0, 0, 0, "R2 below M ignores MIE");
        scenario(32'h20, 32'h20, 2'd1, 0, 1, 0, "R3 S mode SIE set");
        scenario(32'h20, 32'h20, 2'd1, 0, 0, 0, "R3 S mode SIE clear");
        scenario(32'h20, 32'h20, 2'd0, 0, 0, 0, "R3 U mode");
        scenario(32'h20, 32'h20, 2'd3, 1, 1, 0, "R3 M mode blocks delegated");
        scenario(32'h280, 32'h200, 2'd1, 0, 1, 0, "R4 non-delegated first");
        scenario(32'h202, 32'h202, 2'd0, 0, 0, 0, "R4 delegated fallback");
        scenario(32'h1_0888, 0, 2'd3, 1, 0, 0, "R6 custom class first");
        scenario(32'h888, 0, 2'd3, 1, 0, 0, "R6 external over software");
        scenario(32'h88, 0, 2'd3, 1, 0, 0, "R6 software over timer");
        scenario(32'hA00, 0, 2'd3, 1, 0, 0, "R7 lowest external");
        scenario(32'h8010_0000, 0, 2'd3, 1, 0, 0, "R7 lowest custom");
        scenario(32'h8000_0000, 0, 2'd3, 1, 0, 0, "R8 top index");
        scenario(32'h555, 0, 2'd3, 1, 0, 0, "R11 unclassed bits");
        scenario(32'h120, 0, 2'd3, 1, 0, 0, "R11 timer beside unclassed");
        scenario(32'h800, 0, 2'd3, 1, 0, 1, "R5 debug blocks");

        // R10: hold with a higher interrupt pending, then accept and re-arm
        drive(32'h08, 0, 2'd3, 1, 0, 0, "R10 first take", f);
        pend_i = 32'h1_0000;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #2;
            check(take_o == 1'b0 && cause_o == 32'h8000_0003,
                  "R10 held cause", cause_o, 32'h8000_0003);
        end
        accept_i = 1'b1;
        exp_q.push_back(32'h8000_0010);
        tag_q.push_back("R9 re-arm after accept");
        @(negedge clk);
        accept_i = 1'b0;
        check(cause_o == '0 && take_o == 1'b0, "R10 cleared on accept", cause_o, '0);
        @(negedge clk);
        #2;
        check(exp_q.size() == 0, "R9 re-arm missing", {31'd0, take_o}, 1);
        release_cause(1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule